// File: doc/BRIEF.md
# Suspend and Wake Power Sequencer

This block steps a device into and back out of a low-power suspend state. A suspend request starts the entry sequence. The AWAKE line is driven low first. The I/O override then moves the outputs to their suspend behaviour. Last, the inputs and internal interconnect are blocked. Write protection of clocked storage is raised as soon as entry begins. Each entry step waits its own programmable number of cycles.

Exit begins when the suspend request falls. In multi-pin mode, an enabled wake pin must also be seen high after the suspend request was seen low. The input block is released first, while write protection stays on. After a programmable delay, AWAKE is either driven high or released to an external pull-up (open-drain mode). The block then waits for the sensed AWAKE line to read high. The output override is released a configurable number of cycles after that point. Write protection is removed later still, so outputs are always enabled before storage becomes writable.

The suspend request, the wake pins and the sensed AWAKE line each pass through two-flop synchronisers. A phase output reports where the sequence stands.

Top module: `suspend_wake_seq`

## Requirements
- R1: After reset: phase_o is 0 (awake), awake_drive_o is 1, gts_o, block_o and write_protect_o are 0, and awake_oe_o equals drive_mode_i.
- R2: Entry, measured from the cycle in which the synchronised suspend request is first seen high:
  - write_protect_o rises at once;
  - awake_drive_o falls (awake_oe_o 1) dly_awake_i cycles later;
  - gts_o rises dly_gts_i cycles after that;
  - block_o rises dly_block_i cycles after that.
  A delay value of 0 acts as 1.
- R3: In single-pin mode (multi_pin_mode_i=0), a synchronised suspend request seen low while suspended clears block_o on the next edge.
- R4: In multi-pin mode, exit needs the synchronised suspend request low, followed in a later cycle by a pin high that is enabled in wake_en_i. Pins whose wake_en_i bit is 0 are ignored, and the block stays suspended (phase_o 2).
- R5: write_protect_o and gts_o remain 1 while block_o is released.
- R6: dly_release_i cycles after block_o falls (0 acts as 1), awake_drive_o returns to 1. In drive mode (drive_mode_i=1), awake_oe_o stays 1.
- R7: In open-drain mode (drive_mode_i=0), awake_oe_o is 0 once AWAKE is released. The block holds phase 4 until the synchronised awake_sense_i reads high.
- R8: gts_o falls G cycles after the cycle in which the synchronised sensed AWAKE is first seen high, where G = max(gts_cyc_i, 1).
- R9: write_protect_o falls gwe_cyc_i cycles after that same point. If gwe_cyc_i <= G, it falls G+1 cycles after instead. The phase then returns to 0.
- R10: A suspend request that rises during an exit sequence is ignored until phase 0 is reached.
- R11: Phase codes are 0 awake, 1 entering, 2 suspended, 3 waking (unblocking or releasing), 4 waiting for AWAKE.
- R12: suspend_i, wake_pins_i and awake_sense_i take effect on the state after two synchroniser flops. A suspend request driven before edge n first changes phase_o at edge n+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| suspend_i | input | 1 | Suspend request, asynchronous |
| wake_pins_i | input | NUM_WAKE | Wake-up pins, asynchronous |
| wake_en_i | input | NUM_WAKE | Per-pin wake enable |
| multi_pin_mode_i | input | 1 | 1: exit also needs an enabled wake pin |
| drive_mode_i | input | 1 | 1: drive AWAKE high; 0: open-drain release |
| awake_sense_i | input | 1 | Sensed level of the AWAKE line |
| dly_awake_i | input | CNT_W | Cycles from entry start to AWAKE low |
| dly_gts_i | input | CNT_W | Cycles from AWAKE low to output override |
| dly_block_i | input | CNT_W | Cycles from override to input block |
| dly_release_i | input | CNT_W | Cycles from unblock to AWAKE release |
| gts_cyc_i | input | CNT_W | Cycles from AWAKE high to override release |
| gwe_cyc_i | input | CNT_W | Cycles from AWAKE high to write-protect release |
| awake_drive_o | output | 1 | Value for the AWAKE pad |
| awake_oe_o | output | 1 | Enable for the AWAKE pad driver |
| gts_o | output | 1 | Output override active (suspend I/O behaviour) |
| block_o | output | 1 | Inputs and interconnect blocked |
| write_protect_o | output | 1 | Clocked storage write-protected |
| phase_o | output | 3 | Current phase code (R11) |

## Verification
The ordering assertions rely on the configuration inputs staying constant from the start of an entry until the return to phase 0. The stimulus changes them only while the reference model reports phase 0 and no suspend request is pending. The sensed AWAKE line is fed by the bench. It follows the block's own pad drive whenever awake_oe_o is 1. Otherwise it follows an external pull level, which the bench holds low for a while to exercise the open-drain wait.

// File: rtl/swseq_pkg.sv
package swseq_pkg;
  typedef enum logic [2:0] {
    ST_AWAKE, ST_E_AWK, ST_E_GTS, ST_E_BLK,
    ST_SUSP, ST_X_UNB, ST_X_WAIT, ST_X_REL
  } seq_state_e;

  localparam logic [2:0] PH_AWAKE = 3'd0;
  localparam logic [2:0] PH_ENTER = 3'd1;
  localparam logic [2:0] PH_SUSP  = 3'd2;
  localparam logic [2:0] PH_WAKE  = 3'd3;
  localparam logic [2:0] PH_WAIT  = 3'd4;

  function automatic logic [2:0] phase_of(seq_state_e s);
    case (s)
      ST_AWAKE:                     phase_of = PH_AWAKE;
      ST_E_AWK, ST_E_GTS, ST_E_BLK: phase_of = PH_ENTER;
      ST_SUSP:                      phase_of = PH_SUSP;
      ST_X_WAIT:                    phase_of = PH_WAIT;
      default:                      phase_of = PH_WAKE;
    endcase
  endfunction
endpackage

// File: rtl/swseq_sync.sv
module swseq_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [1:0] ff_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff_q <= 2'b00;
      else         ff_q <= {ff_q[0], d_i[g]};
    end
    assign q_o[g] = ff_q[1];
  end
endmodule

// File: rtl/swseq_wake_detect.sv
module swseq_wake_detect #(
  parameter int NUM_WAKE = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                in_susp_i,
  input  logic                susp_s_i,
  input  logic                multi_i,
  input  logic [NUM_WAKE-1:0] pins_s_i,
  input  logic [NUM_WAKE-1:0] en_i,
  output logic                wake_go_o
);
  logic armed_q;
  logic any_pin;

  // armed once suspend has been seen low in a previous suspended cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= in_susp_i & ~susp_s_i;
  end

  assign any_pin   = |(pins_s_i & en_i);
  assign wake_go_o = ~susp_s_i & (multi_i ? (armed_q & any_pin) : 1'b1);
endmodule

// File: rtl/swseq_release.sv
module swseq_release #(
  parameter int CNT_W = 8
) (
  input  logic [CNT_W-1:0] gts_cyc_i,
  input  logic [CNT_W-1:0] gwe_cyc_i,
  output logic [CNT_W:0]   gts_at_o,
  output logic [CNT_W:0]   gwe_at_o
);
  localparam int RW = CNT_W + 1;

  always_comb begin
    gts_at_o = (gts_cyc_i == '0) ? RW'(1) : RW'(gts_cyc_i);
    if (RW'(gwe_cyc_i) <= gts_at_o) gwe_at_o = gts_at_o + RW'(1);
    else                            gwe_at_o = RW'(gwe_cyc_i);
  end
endmodule

// File: rtl/swseq_core.sv
module swseq_core
  import swseq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             susp_s_i,
  input  logic             awake_s_i,
  input  logic             wake_go_i,
  input  logic [CNT_W-1:0] dly_awake_i,
  input  logic [CNT_W-1:0] dly_gts_i,
  input  logic [CNT_W-1:0] dly_block_i,
  input  logic [CNT_W-1:0] dly_release_i,
  input  logic [CNT_W:0]   gts_at_i,
  input  logic [CNT_W:0]   gwe_at_i,
  output logic             in_susp_o,
  output logic             awake_low_o,
  output logic             gts_o,
  output logic             block_o,
  output logic             wp_o,
  output logic [2:0]       phase_o
);
  localparam int RW = CNT_W + 1;

  seq_state_e       st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [RW-1:0]    rel_q;
  logic             cnt_done;

  function automatic logic [CNT_W-1:0] load(logic [CNT_W-1:0] d);
    return (d == '0) ? '0 : d - CNT_W'(1);
  endfunction

  assign cnt_done = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_AWAKE;
      cnt_q       <= '0;
      rel_q       <= '0;
      awake_low_o <= 1'b0;
      gts_o       <= 1'b0;
      block_o     <= 1'b0;
      wp_o        <= 1'b0;
    end else begin
      case (st_q)
        ST_AWAKE: if (susp_s_i) begin
          st_q  <= ST_E_AWK;
          cnt_q <= load(dly_awake_i);
          wp_o  <= 1'b1;
        end
        ST_E_AWK: if (cnt_done) begin
          awake_low_o <= 1'b1;
          st_q        <= ST_E_GTS;
          cnt_q       <= load(dly_gts_i);
        end else cnt_q <= cnt_q - CNT_W'(1);
        ST_E_GTS: if (cnt_done) begin
          gts_o <= 1'b1;
          st_q  <= ST_E_BLK;
          cnt_q <= load(dly_block_i);
        end else cnt_q <= cnt_q - CNT_W'(1);
        ST_E_BLK: if (cnt_done) begin
          block_o <= 1'b1;
          st_q    <= ST_SUSP;
        end else cnt_q <= cnt_q - CNT_W'(1);
        ST_SUSP: if (wake_go_i) begin
          block_o <= 1'b0;
          st_q    <= ST_X_UNB;
          cnt_q   <= load(dly_release_i);
        end
        ST_X_UNB: if (cnt_done) begin
          awake_low_o <= 1'b0;
          st_q        <= ST_X_WAIT;
        end else cnt_q <= cnt_q - CNT_W'(1);
        ST_X_WAIT: if (awake_s_i) begin
          st_q  <= ST_X_REL;
          rel_q <= RW'(1);
        end
        ST_X_REL: begin
          if (rel_q == gts_at_i) gts_o <= 1'b0;
          if (rel_q == gwe_at_i) begin
            wp_o <= 1'b0;
            st_q <= ST_AWAKE;
          end
          rel_q <= rel_q + RW'(1);
        end
        default: st_q <= ST_AWAKE;
      endcase
    end
  end

  assign in_susp_o = (st_q == ST_SUSP);
  assign phase_o   = phase_of(st_q);
endmodule

// File: rtl/suspend_wake_seq.sv
module suspend_wake_seq #(
  parameter int NUM_WAKE = 4,
  parameter int CNT_W    = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                suspend_i,
  input  logic [NUM_WAKE-1:0] wake_pins_i,
  input  logic [NUM_WAKE-1:0] wake_en_i,
  input  logic                multi_pin_mode_i,
  input  logic                drive_mode_i,
  input  logic                awake_sense_i,
  input  logic [CNT_W-1:0]    dly_awake_i,
  input  logic [CNT_W-1:0]    dly_gts_i,
  input  logic [CNT_W-1:0]    dly_block_i,
  input  logic [CNT_W-1:0]    dly_release_i,
  input  logic [CNT_W-1:0]    gts_cyc_i,
  input  logic [CNT_W-1:0]    gwe_cyc_i,
  output logic                awake_drive_o,
  output logic                awake_oe_o,
  output logic                gts_o,
  output logic                block_o,
  output logic                write_protect_o,
  output logic [2:0]          phase_o
);
  localparam int SW = NUM_WAKE + 2;

  logic [SW-1:0]       sync_q;
  logic                susp_s, awake_s;
  logic [NUM_WAKE-1:0] pins_s;
  logic                wake_go, in_susp, awake_low;
  logic [CNT_W:0]      gts_at, gwe_at;

  swseq_sync #(.W(SW)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({awake_sense_i, suspend_i, wake_pins_i}),
    .q_o   (sync_q)
  );
  assign pins_s  = sync_q[NUM_WAKE-1:0];
  assign susp_s  = sync_q[NUM_WAKE];
  assign awake_s = sync_q[NUM_WAKE+1];

  swseq_wake_detect #(.NUM_WAKE(NUM_WAKE)) u_wake (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .in_susp_i(in_susp),
    .susp_s_i (susp_s),
    .multi_i  (multi_pin_mode_i),
    .pins_s_i (pins_s),
    .en_i     (wake_en_i),
    .wake_go_o(wake_go)
  );

  swseq_release #(.CNT_W(CNT_W)) u_rel (
    .gts_cyc_i(gts_cyc_i),
    .gwe_cyc_i(gwe_cyc_i),
    .gts_at_o (gts_at),
    .gwe_at_o (gwe_at)
  );

  swseq_core #(.CNT_W(CNT_W)) u_core (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .susp_s_i     (susp_s),
    .awake_s_i    (awake_s),
    .wake_go_i    (wake_go),
    .dly_awake_i  (dly_awake_i),
    .dly_gts_i    (dly_gts_i),
    .dly_block_i  (dly_block_i),
    .dly_release_i(dly_release_i),
    .gts_at_i     (gts_at),
    .gwe_at_i     (gwe_at),
    .in_susp_o    (in_susp),
    .awake_low_o  (awake_low),
    .gts_o        (gts_o),
    .block_o      (block_o),
    .wp_o         (write_protect_o),
    .phase_o      (phase_o)
  );

  assign awake_drive_o = ~awake_low;
  assign awake_oe_o    = awake_low | drive_mode_i;
endmodule

// File: rtl/swseq_checker.sv
module swseq_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       drive_mode_i,
  input logic       awake_drive_o,
  input logic       awake_oe_o,
  input logic       gts_o,
  input logic       block_o,
  input logic       write_protect_o,
  input logic [2:0] phase_o
);
  assert_block_nested_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    block_o |-> (gts_o && write_protect_o && !awake_drive_o));

  assert_awake_low_first_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gts_o) |-> !awake_drive_o);

  assert_unblock_protected_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(block_o) |-> (write_protect_o && gts_o));

  assert_gts_after_unblock_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(gts_o) |-> (!block_o && awake_drive_o));

  assert_wp_after_gts_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(write_protect_o) |-> ($past(!gts_o) && phase_o == 3'd0));

  assert_open_drain_wait_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 3'd4 && !drive_mode_i) |-> !awake_oe_o);

  assert_phase_legal_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o <= 3'd4);

  assert_awake_clean_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 3'd0) |-> (!gts_o && !block_o && awake_drive_o));
endmodule

bind suspend_wake_seq swseq_checker u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .drive_mode_i   (drive_mode_i),
  .awake_drive_o  (awake_drive_o),
  .awake_oe_o     (awake_oe_o),
  .gts_o          (gts_o),
  .block_o        (block_o),
  .write_protect_o(write_protect_o),
  .phase_o        (phase_o)
);

// File: tb/sim_suspend_wake_seq.sv
`timescale 1ns/1ps
module sim_suspend_wake_seq;
  localparam int NW = 4;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          suspend = 1'b0;
  logic [NW-1:0] pins = '0, wen = '0;
  logic          multi = 1'b0, dmode = 1'b1, ext_pull = 1'b1;
  logic [7:0]    d_awk = 8'd1, d_gts = 8'd1, d_blk = 8'd1, d_rel = 8'd1;
  logic [7:0]    c_gts = 8'd4, c_gwe = 8'd5;
  logic          aw_drv, aw_oe, gts, blk, wp;
  logic [2:0]    phase;
  wire           aw_sense = aw_oe ? aw_drv : ext_pull;

  int    n_chk = 0, n_err = 0, cyc = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  suspend_wake_seq u0 (
    .clk_i(clk), .rst_ni(rst_ni), .suspend_i(suspend), .wake_pins_i(pins),
    .wake_en_i(wen), .multi_pin_mode_i(multi), .drive_mode_i(dmode),
    .awake_sense_i(aw_sense), .dly_awake_i(d_awk), .dly_gts_i(d_gts),
    .dly_block_i(d_blk), .dly_release_i(d_rel), .gts_cyc_i(c_gts),
    .gwe_cyc_i(c_gwe), .awake_drive_o(aw_drv), .awake_oe_o(aw_oe),
    .gts_o(gts), .block_o(blk), .write_protect_o(wp), .phase_o(phase)
  );

  // behavioural reference model
  int     m_step, m_left, m_rc, m_phase;
  bit     m_low, m_gts, m_blk, m_wp, m_armed;
  bit     qs[$], qa[$];
  logic [NW-1:0] qw[$];

  function automatic int eff(int d);
    return (d == 0) ? 1 : d;
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_step = 0; m_left = 0; m_rc = 0;
      m_low = 0; m_gts = 0; m_blk = 0; m_wp = 0; m_armed = 0;
      qs = '{0, 0}; qa = '{0, 0}; qw = '{'0, '0};
    end else begin
      bit s, a, go, was_susp;
      int g_at, w_at;
      s = qs[0]; a = qa[0];
      g_at = eff(c_gts);
      w_at = (c_gwe <= g_at) ? g_at + 1 : c_gwe;
      was_susp = (m_step == 4);
      go = !s && (multi ? (m_armed && (|(qw[0] & wen))) : 1'b1);
      m_armed = was_susp && !s;
      case (m_step)
        0: if (s) begin m_step = 1; m_left = eff(d_awk); m_wp = 1; end
        1: begin m_left--; if (m_left == 0) begin m_low = 1; m_step = 2; m_left = eff(d_gts); end end
        2: begin m_left--; if (m_left == 0) begin m_gts = 1; m_step = 3; m_left = eff(d_blk); end end
        3: begin m_left--; if (m_left == 0) begin m_blk = 1; m_step = 4; end end
        4: if (go) begin m_blk = 0; m_step = 5; m_left = eff(d_rel); end
        5: begin m_left--; if (m_left == 0) begin m_low = 0; m_step = 6; end end
        6: if (a) begin m_step = 7; m_rc = 1; end
        default: begin
          if (m_rc == g_at) m_gts = 0;
          if (m_rc == w_at) begin m_wp = 0; m_step = 0; end
          m_rc++;
        end
      endcase
      void'(qs.pop_front()); qs.push_back(suspend);
      void'(qa.pop_front()); qa.push_back(aw_sense);
      void'(qw.pop_front()); qw.push_back(pins);
    end
  end

  always_comb begin
    case (m_step)
      0: m_phase = 0;
      1, 2, 3: m_phase = 1;
      4: m_phase = 2;
      6: m_phase = 4;
      default: m_phase = 3;
    endcase
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    cyc++;
    if (rst_ni) begin
      chk(aw_drv == !m_low, cur_req, "awake_drive", aw_drv, !m_low);
      chk(aw_oe == (m_low || dmode), cur_req, "awake_oe", aw_oe, m_low || dmode);
      chk(gts == m_gts, cur_req, "gts", gts, m_gts);
      chk(blk == m_blk, cur_req, "block", blk, m_blk);
      chk(wp == m_wp, cur_req, "write_protect", wp, m_wp);
      chk(phase == 3'(m_phase), cur_req, "phase", phase, m_phase);
    end
  end

  task automatic wait_model(int p, int lim);
    for (int i = 0; i < lim; i++) begin
      if (m_phase == p) return;
      @(negedge clk);
    end
    chk(0, cur_req, "timeout waiting phase", m_phase, p);
  endtask

  task automatic cycle_once(string req);
    cur_req = req;
    @(negedge clk);
    suspend = 1'b1;
    wait_model(2, 2000);
    repeat (3) @(negedge clk);
    suspend = 1'b0;
    wait_model(0, 2000);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(phase == 3'd0 && aw_drv && aw_oe && !gts && !blk && !wp, "R1", "reset outputs",
        {phase, aw_drv, aw_oe, gts, blk, wp}, 6'b000110);

    // R12 two-flop latency on suspend
    cur_req = "R12";
    suspend = 1'b1;
    @(negedge clk); chk(phase == 3'd0, "R12", "phase after 1 edge", phase, 0);
    @(negedge clk); chk(phase == 3'd0, "R12", "phase after 2 edges", phase, 0);
    @(negedge clk); chk(phase == 3'd1 && wp, "R12", "phase after 3 edges", phase, 1);
    cur_req = "R2 R11";
    wait_model(2, 2000);
    suspend = 1'b0;
    cur_req = "R3 R5 R6 R8 R9";
    wait_model(0, 2000);
    repeat (4) @(negedge clk);

    // R2 longer delays, R8 and R9 with spread counts
    d_awk = 8'd3; d_gts = 8'd5; d_blk = 8'd2; d_rel = 8'd4; c_gts = 8'd6; c_gwe = 8'd11;
    cycle_once("R2 R6 R8 R9");

    // R9 zero counts act as one, gwe clamped
    d_awk = 8'd0; d_gts = 8'd0; d_blk = 8'd0; d_rel = 8'd0; c_gts = 8'd0; c_gwe = 8'd0;
    cycle_once("R9 R2");
    d_awk = 8'd2; d_gts = 8'd1; d_blk = 8'd1; d_rel = 8'd2; c_gts = 8'd7; c_gwe = 8'd3;
    cycle_once("R9");

    // R7 open-drain with external hold-off
    cur_req = "R7";
    dmode = 1'b0; c_gts = 8'd4; c_gwe = 8'd5;
    @(negedge clk);
    suspend = 1'b1;
    wait_model(2, 2000);
    ext_pull = 1'b0;
    suspend = 1'b0;
    wait_model(4, 2000);
    repeat (12) @(negedge clk);
    chk(phase == 3'd4 && !aw_oe, "R7", "held waiting", phase, 4);
    ext_pull = 1'b1;
    wait_model(0, 2000);
    repeat (4) @(negedge clk);
    dmode = 1'b1;

    // R4 multi-pin wake, disabled pin ignored
    cur_req = "R4";
    multi = 1'b1; wen = 4'b0010;
    @(negedge clk);
    suspend = 1'b1;
    wait_model(2, 2000);
    suspend = 1'b0;
    pins = 4'b0001;
    repeat (20) @(negedge clk);
    chk(phase == 3'd2 && blk, "R4", "disabled pin ignored", phase, 2);
    pins = 4'b0010;
    wait_model(0, 2000);
    pins = 4'b0000;
    repeat (4) @(negedge clk);
    // R4 suspend still high: enabled pin alone does not wake
    @(negedge clk);
    suspend = 1'b1;
    wait_model(2, 2000);
    pins = 4'b0010;
    repeat (15) @(negedge clk);
    chk(phase == 3'd2, "R4", "pin while suspend high", phase, 2);
    suspend = 1'b0;
    wait_model(0, 2000);
    pins = 4'b0000;
    multi = 1'b0; wen = '0;
    repeat (4) @(negedge clk);

    // R10 suspend re-raised during exit
    cur_req = "R10";
    d_rel = 8'd6;
    @(negedge clk);
    suspend = 1'b1;
    wait_model(2, 2000);
    suspend = 1'b0;
    wait_model(3, 2000);
    suspend = 1'b1;
    for (int i = 0; i < 200; i++) begin
      if (phase == 3'd0) break;
      chk(phase != 3'd1, "R10", "no re-entry during exit", phase, 3);
      @(negedge clk);
    end
    chk(phase == 3'd0 && !wp, "R10", "exit completed", phase, 0);
    wait_model(2, 2000);
    suspend = 1'b0;
    wait_model(0, 2000);
    repeat (4) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule